// File: doc/BRIEF.md
# Multiport DRAM Cycle-Type Decoder

This block sits in front of the control logic of a dual-port memory that has a random-access array and a serial register. It watches the active-low row and column strobes and the mode inputs on a system clock. At each falling edge of the row strobe it decides which kind of memory cycle is starting: an ordinary array access, a masked (write-per-bit) write, one of three kinds of transfer between the array and the serial register, a refresh driven by the internal counter, or an illegal combination. The data pins are sampled at that same edge to form the write mask.

The decoded cycle type is a one-hot vector that stays steady for the whole row cycle. It returns to all zeros when the row strobe rises. The row address and the mask are latched with it. During an ordinary or masked cycle, every later fall of the column strobe captures a column address and raises a one-cycle event pulse, which supports page-mode sequences. The event pulse is a plain notification and accepts no back-pressure. A consumer that needs flow control must buffer it.

All inputs are taken as synchronous to `clk`. Each input passes through one register stage. A change presented before rising edge N shows up on the outputs after rising edge N+1.

Top module: `mdt_cycle_decoder`

## Requirements
- R1: After reset, `cyc_kind_o` is 0, `wmask_o` is all ones, `row_addr_o` and `col_addr_o` are 0, and `col_evt_o` is 0.
- R2: With the transfer input high and the column strobe high at the row fall, the cycle is an ordinary access (bit 0) when the write-mode input is high, and a masked write (bit 1) when it is low. Outputs change on the second rising edge after the inputs are presented.
- R3: With the transfer input low, the column strobe high and the write-mode input high, the cycle is a read transfer (bit 2), whatever the serial-enable level.
- R4: With the transfer input low, the column strobe high, the write-mode input low and serial enable high, the cycle is a pseudo write transfer (bit 4).
- R5: With the transfer input, the column strobe, the write-mode input and serial enable all low, the cycle is a write transfer (bit 3).
- R6: With the transfer input high and the column strobe already low at the row fall, the cycle is a refresh (bit 5), whatever the write-mode and serial-enable levels.
- R7: Every other combination sets only the illegal bit (bit 6).
- R8: For a masked write, `wmask_o` takes `dq_i` as sampled at the row fall, where 1 enables a bit and 0 inhibits it. For any other cycle, and when idle, `wmask_o` is all ones.
- R9: `row_addr_o` takes `addr_i` at the row fall and holds it until the next row fall.
- R10: For the whole row cycle, the cycle type and the mask ignore later changes on the mode inputs and `dq_i`. When the row strobe rises, `cyc_kind_o` returns to 0 and `wmask_o` returns to all ones, with the R2 latency.
- R11: In an ordinary or masked cycle, each fall of the column strobe loads `addr_i` into `col_addr_o` and pulses `col_evt_o` for exactly one cycle, with the R2 latency. The mask does not change across these page accesses.
- R12: A column-strobe fall while idle, or during a transfer, refresh or illegal cycle, produces no `col_evt_o` and leaves `col_addr_o` unchanged.
- R13: At most one bit of `cyc_kind_o` is set at any time, and exactly one is set during a row cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| row_stb_n_i | input | 1 | Row strobe, active low |
| col_stb_n_i | input | 1 | Column strobe, active low |
| xfer_oe_n_i | input | 1 | Low at the row fall selects a transfer; high selects an array cycle (output-enable role) |
| wmode_n_i | input | 1 | Write mode: low selects masked write or the SAM-to-RAM direction |
| ser_en_n_i | input | 1 | Serial enable, active low |
| dq_i | input | DQ_W | Data pins, used as the mask at the row fall |
| addr_i | input | ADDR_W | Multiplexed row/column address |
| cyc_kind_o | output | 7 | One-hot cycle type (bits given in R2 to R7) |
| wmask_o | output | DQ_W | Latched write mask |
| row_addr_o | output | ADDR_W | Latched row address |
| col_addr_o | output | ADDR_W | Last captured column address |
| col_evt_o | output | 1 | One-cycle pulse when a column address is captured |

## Verification
The bench runs every one of the sixteen level combinations of the column strobe, the transfer input, the write-mode input and serial enable through a full row cycle. It does this twice, with different mask and row-address patterns. This separates each decode region from its neighbours, and it shows that don't-care inputs really are ignored. Inside each row cycle, the mode and data inputs are flipped to confirm that the decode and mask stay latched. Two column-strobe falls then show that page-mode captures happen only in array cycles. A column fall while idle and the return to idle at each row rise cover the edges of the cycle.

// File: rtl/mdt_pkg.sv
package mdt_pkg;
  localparam int KIND_W = 7;
  localparam int K_NORM = 0;
  localparam int K_WPB  = 1;
  localparam int K_RDX  = 2;
  localparam int K_WRX  = 3;
  localparam int K_PWX  = 4;
  localparam int K_RFSH = 5;
  localparam int K_ILL  = 6;
endpackage

// File: rtl/mdt_strobe_sampler.sv
module mdt_strobe_sampler #(
  parameter int ADDR_W = 9,
  parameter int DQ_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              row_n_i,
  input  logic              col_n_i,
  input  logic              xfer_n_i,
  input  logic              wmode_n_i,
  input  logic              ser_n_i,
  input  logic [DQ_W-1:0]   dq_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              s_row_n,
  output logic              s_col_n,
  output logic              s_xfer_n,
  output logic              s_wmode_n,
  output logic              s_ser_n,
  output logic [DQ_W-1:0]   s_dq,
  output logic [ADDR_W-1:0] s_addr,
  output logic              row_fall,
  output logic              row_rise,
  output logic              col_fall
);
  logic prev_row, prev_col;

  // one register stage on every input, then edge detection on the strobes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_row_n   <= 1'b1;
      s_col_n   <= 1'b1;
      s_xfer_n  <= 1'b1;
      s_wmode_n <= 1'b1;
      s_ser_n   <= 1'b1;
      s_dq      <= '0;
      s_addr    <= '0;
      prev_row  <= 1'b1;
      prev_col  <= 1'b1;
    end else begin
      s_row_n   <= row_n_i;
      s_col_n   <= col_n_i;
      s_xfer_n  <= xfer_n_i;
      s_wmode_n <= wmode_n_i;
      s_ser_n   <= ser_n_i;
      s_dq      <= dq_i;
      s_addr    <= addr_i;
      prev_row  <= s_row_n;
      prev_col  <= s_col_n;
    end
  end

  assign row_fall = prev_row & ~s_row_n;
  assign row_rise = ~prev_row & s_row_n;
  assign col_fall = prev_col & ~s_col_n;
endmodule

// File: rtl/mdt_cycle_classifier.sv
module mdt_cycle_classifier
  import mdt_pkg::*;
(
  input  logic              col_n_i,
  input  logic              xfer_n_i,
  input  logic              wmode_n_i,
  input  logic              ser_n_i,
  output logic [KIND_W-1:0] kind_o
);
  always_comb begin
    kind_o = '0;
    if (xfer_n_i) begin
      // array cycle family: a column strobe already low means internal refresh
      if (!col_n_i)        kind_o[K_RFSH] = 1'b1;
      else if (!wmode_n_i) kind_o[K_WPB]  = 1'b1;
      else                 kind_o[K_NORM] = 1'b1;
    end else if (col_n_i && wmode_n_i) begin
      kind_o[K_RDX] = 1'b1;
    end else if (col_n_i && ser_n_i) begin
      kind_o[K_PWX] = 1'b1;
    end else if (!col_n_i && !wmode_n_i && !ser_n_i) begin
      kind_o[K_WRX] = 1'b1;
    end else begin
      kind_o[K_ILL] = 1'b1;
    end
  end
endmodule

// File: rtl/mdt_row_latch.sv
module mdt_row_latch
  import mdt_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DQ_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              row_fall,
  input  logic              row_rise,
  input  logic [KIND_W-1:0] kind_in,
  input  logic [DQ_W-1:0]   s_dq,
  input  logic [ADDR_W-1:0] s_addr,
  output logic [KIND_W-1:0] kind_q,
  output logic [DQ_W-1:0]   mask_q,
  output logic [ADDR_W-1:0] row_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= '0;
      row_q  <= '0;
    end else if (row_fall) begin
      kind_q <= kind_in;
      row_q  <= s_addr;
    end else if (row_rise) begin
      kind_q <= '0;
    end
  end

  // per-lane mask: data pin when masked write is chosen, otherwise enabled
  for (genvar b = 0; b < DQ_W; b++) begin : g_mask
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        mask_q[b] <= 1'b1;
      else if (row_fall) mask_q[b] <= kind_in[K_WPB] ? s_dq[b] : 1'b1;
      else if (row_rise) mask_q[b] <= 1'b1;
    end
  end
endmodule

// File: rtl/mdt_column_tracker.sv
module mdt_column_tracker #(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              col_fall,
  input  logic              row_low,
  input  logic              ram_cycle,
  input  logic [ADDR_W-1:0] s_addr,
  output logic [ADDR_W-1:0] col_q,
  output logic              evt_q
);
  logic take;
  assign take = col_fall & row_low & ram_cycle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= '0;
      evt_q <= 1'b0;
    end else begin
      evt_q <= take;
      if (take) col_q <= s_addr;
    end
  end
endmodule

// File: rtl/mdt_cycle_decoder.sv
module mdt_cycle_decoder
  import mdt_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DQ_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              row_stb_n_i,
  input  logic              col_stb_n_i,
  input  logic              xfer_oe_n_i,
  input  logic              wmode_n_i,
  input  logic              ser_en_n_i,
  input  logic [DQ_W-1:0]   dq_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [KIND_W-1:0] cyc_kind_o,
  output logic [DQ_W-1:0]   wmask_o,
  output logic [ADDR_W-1:0] row_addr_o,
  output logic [ADDR_W-1:0] col_addr_o,
  output logic              col_evt_o
);
  logic              s_row_n, s_col_n, s_xfer_n, s_wmode_n, s_ser_n;
  logic [DQ_W-1:0]   s_dq;
  logic [ADDR_W-1:0] s_addr;
  logic              row_fall, row_rise, col_fall;
  logic [KIND_W-1:0] kind_now;

  mdt_strobe_sampler #(.ADDR_W(ADDR_W), .DQ_W(DQ_W)) smp_i (
    .clk(clk), .rst_n(rst_n),
    .row_n_i(row_stb_n_i), .col_n_i(col_stb_n_i), .xfer_n_i(xfer_oe_n_i),
    .wmode_n_i(wmode_n_i), .ser_n_i(ser_en_n_i), .dq_i(dq_i), .addr_i(addr_i),
    .s_row_n(s_row_n), .s_col_n(s_col_n), .s_xfer_n(s_xfer_n),
    .s_wmode_n(s_wmode_n), .s_ser_n(s_ser_n), .s_dq(s_dq), .s_addr(s_addr),
    .row_fall(row_fall), .row_rise(row_rise), .col_fall(col_fall)
  );

  mdt_cycle_classifier cls_i (
    .col_n_i(s_col_n), .xfer_n_i(s_xfer_n), .wmode_n_i(s_wmode_n),
    .ser_n_i(s_ser_n), .kind_o(kind_now)
  );

  mdt_row_latch #(.ADDR_W(ADDR_W), .DQ_W(DQ_W)) row_i (
    .clk(clk), .rst_n(rst_n), .row_fall(row_fall), .row_rise(row_rise),
    .kind_in(kind_now), .s_dq(s_dq), .s_addr(s_addr),
    .kind_q(cyc_kind_o), .mask_q(wmask_o), .row_q(row_addr_o)
  );

  mdt_column_tracker #(.ADDR_W(ADDR_W)) col_i (
    .clk(clk), .rst_n(rst_n), .col_fall(col_fall), .row_low(~s_row_n),
    .ram_cycle(cyc_kind_o[K_NORM] | cyc_kind_o[K_WPB]), .s_addr(s_addr),
    .col_q(col_addr_o), .evt_q(col_evt_o)
  );
endmodule

// File: rtl/mdt_cycle_decoder_chk.sv
module mdt_cycle_decoder_chk
  import mdt_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DQ_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [KIND_W-1:0] cyc_kind_o,
  input logic [DQ_W-1:0]   wmask_o,
  input logic [ADDR_W-1:0] row_addr_o,
  input logic [ADDR_W-1:0] col_addr_o,
  input logic              col_evt_o
);
  p_onehot_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cyc_kind_o));

  p_mask_ones_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_kind_o[K_WPB] |-> (wmask_o == {DQ_W{1'b1}}));

  p_kind_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|cyc_kind_o) |=> ((cyc_kind_o == $past(cyc_kind_o)) || (cyc_kind_o == '0)));

  p_mask_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((|cyc_kind_o) && (|$past(cyc_kind_o))) |-> $stable(wmask_o));

  p_row_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((|cyc_kind_o) && (|$past(cyc_kind_o))) |-> $stable(row_addr_o));

  p_evt_ram_r11: assert property (@(posedge clk) disable iff (!rst_n)
    col_evt_o |-> (cyc_kind_o[K_NORM] || cyc_kind_o[K_WPB]));

  p_evt_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    col_evt_o |=> !col_evt_o);

  p_col_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !col_evt_o |-> $stable(col_addr_o));
endmodule

bind mdt_cycle_decoder mdt_cycle_decoder_chk #(.ADDR_W(ADDR_W), .DQ_W(DQ_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cyc_kind_o(cyc_kind_o), .wmask_o(wmask_o),
  .row_addr_o(row_addr_o), .col_addr_o(col_addr_o), .col_evt_o(col_evt_o)
);

// File: tb/mdt_cycle_decoder_tb_top.sv
module mdt_cycle_decoder_tb_top;
  localparam int AW = 9;
  localparam int DW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic row_n = 1'b1, col_n = 1'b1, xfer_n = 1'b1, wm_n = 1'b1, se_n = 1'b1;
  logic [DW-1:0] dq = '0;
  logic [AW-1:0] addr = '0;
  logic [6:0]    kind;
  logic [DW-1:0] wmask;
  logic [AW-1:0] row_addr, col_addr;
  logic          col_evt;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mdt_cycle_decoder #(.ADDR_W(AW), .DQ_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .row_stb_n_i(row_n), .col_stb_n_i(col_n),
    .xfer_oe_n_i(xfer_n), .wmode_n_i(wm_n), .ser_en_n_i(se_n), .dq_i(dq),
    .addr_i(addr), .cyc_kind_o(kind), .wmask_o(wmask), .row_addr_o(row_addr),
    .col_addr_o(col_addr), .col_evt_o(col_evt)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected one-hot bit index from the sampled levels (R2..R7)
  function automatic int exp_idx(input bit c, input bit x, input bit w, input bit s);
    if (x) return (!c) ? 5 : (!w ? 1 : 0);
    if (c && w) return 2;
    if (c && !w && s) return 4;
    if (!c && !w && !s) return 3;
    return 6;
  endfunction

  function automatic string idx_tag(input int i);
    case (i)
      0, 1: return "R2";
      2: return "R3";
      3: return "R5";
      4: return "R4";
      5: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic settle();
    @(posedge clk); @(posedge clk); @(negedge clk);
  endtask

  logic [AW-1:0] exp_col = '0;

  task automatic run_row(input bit c, input bit x, input bit w, input bit s,
                         input logic [DW-1:0] m, input logic [AW-1:0] r);
    int idx;
    bit ram;
    logic [DW-1:0] exp_mask;
    logic [AW-1:0] colv;
    idx = exp_idx(c, x, w, s);
    ram = (idx == 0) || (idx == 1);
    exp_mask = (idx == 1) ? m : {DW{1'b1}};
    @(negedge clk);
    col_n = c; xfer_n = x; wm_n = w; se_n = s;
    @(negedge clk);
    row_n = 1'b0; dq = m; addr = r;
    settle();
    check(idx_tag(idx), 16'(kind), 16'(7'(1) << idx));
    check("R13", 16'($countones(kind)), 16'd1);
    check("R8", 16'(wmask), 16'(exp_mask));
    check("R9", 16'(row_addr), 16'(r));
    // disturb inputs inside the row cycle
    xfer_n = ~x; wm_n = ~w; se_n = ~s; dq = ~m; addr = ~r;
    settle();
    check("R10", 16'(kind), 16'(7'(1) << idx));
    check("R10", 16'(wmask), 16'(exp_mask));
    col_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 2; k++) begin
      colv = r ^ AW'(k * 170) ^ AW'(51);
      col_n = 1'b0; addr = colv;
      settle();
      if (ram) begin
        exp_col = colv;
        check("R11", 16'(col_evt), 16'd1);
        check("R11", 16'(col_addr), 16'(exp_col));
        check("R11", 16'(wmask), 16'(exp_mask));
      end else begin
        check("R12", 16'(col_evt), 16'd0);
        check("R12", 16'(col_addr), 16'(exp_col));
      end
      col_n = 1'b1;
      @(negedge clk);
    end
    row_n = 1'b1; xfer_n = 1'b1; wm_n = 1'b1; se_n = 1'b1;
    settle();
    check("R10", 16'(kind), 16'd0);
    check("R10", 16'(wmask), 16'(DW'('1)));
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 16'(kind), 16'd0);
    check("R1", 16'(wmask), 16'(DW'('1)));
    check("R1", 16'(row_addr), 16'd0);
    check("R1", 16'(col_addr), 16'd0);
    check("R1", 16'(col_evt), 16'd0);
    // column fall while idle
    col_n = 1'b0; addr = 9'h155;
    settle();
    check("R12", 16'(col_evt), 16'd0);
    check("R12", 16'(col_addr), 16'd0);
    col_n = 1'b1;
    for (int p = 0; p < 2; p++) begin
      for (int combo = 0; combo < 16; combo++) begin
        run_row(combo[3], combo[2], combo[1], combo[0],
                DW'(combo * 5 + p * 3 + 1), AW'(combo * 37 + p * 200 + 11));
      end
    end
    done = 1'b1;
    report();
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog R1 actual=timeout expected=complete");
      report();
    end
  end
endmodule